// File: doc/BRIEF.md
# Hall Commutation Gate Controller

This block turns three Hall-sensor levels and a rotation-direction bit into the six gate enables of a three-phase MOSFET bridge. Each leg has one high-side and one low-side gate. A chopping command and a current-trip flag decide whether the phase pair picked by the Hall code is driven or recirculating. During recirculation, a decay-mode bit and a synchronous-rectification bit together choose one of four gate patterns. A brake input shorts the windings through the low sides. A driver-disable input coasts the motor and overrides everything else.

Every leg has its own dead-time counter, loaded from a cycle count when one of its gates switches off. The opposing gate of that leg stays low until the counter has run out. A high-side gate may only switch on while the bootstrap-ready flag of its phase is high. All inputs are synchronous and already debounced. The gate outputs and the Hall-fault flag are registered.

Top module: `bldc_gate_ctrl`

## Requirements
- R1: With `dir`=1, `chop`=1 and `trip`=0, the Hall value `hall` (bit0 = sensor A, bit1 = B, bit2 = C) selects a high-side phase and a low-side phase. Phase masks use bit0 = A, bit1 = B, bit2 = C. The mapping is 1: high A, low C; 2: high B, low A; 3: high B, low C; 4: high C, low B; 5: high A, low B; 6: high C, low A. The third phase has both gates off.
- R2: With `dir`=0, the high-side and low-side phases of R1 are exchanged for every valid Hall value.
- R3: Hall values 0 and 7 are illegal. From the next clock edge, all six gates are off and `hall_fault` is 1. For legal values, `hall_fault` is 0 one edge later.
- R4: With `brake_n`=0, a legal Hall value and `drv_off`=0, all three high sides are off and all three low sides are on once dead time has elapsed. An illegal Hall value overrides the brake.
- R5: `drv_off`=1 switches all six gates off at the next edge, whatever `brake_n`, the Hall value or the chop inputs are.
- R6: When `chop`=0 or `trip`=1, the pattern depends on {`mode`,`sr`}. 00 gives all gates off. 10 gives only the selected low side on. 01 turns on the low side of the selected high phase and the high side of the selected low phase. 11 turns on the low sides of both selected phases.
- R7: A gate switches off at the edge after its request drops. The opposing gate of the same leg switches on exactly `dead_cycles`+1 edges after that turn-off when its request is present and no other hold applies. It never switches on earlier.
- R8: A high-side gate switches on only at an edge where `boot_ok` of its phase is 1. It switches on at the first edge with `boot_ok` high once its dead time has expired.
- R9: The high-side and low-side gates of one leg are never high together.
- R10: With `chop` held at 1, `trip` at 0 and the other inputs steady, the selected gates stay on in every cycle (100% duty).
- R11: While `rst` is high, all gates are off and `hall_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 3 | Hall levels, bit0 = A, bit1 = B, bit2 = C |
| dir | input | 1 | Rotation direction, 1 = forward table |
| chop | input | 1 | Chopping command, 1 = drive selected pair |
| trip | input | 1 | Current-trip flag, 1 forces the off-cycle |
| mode | input | 1 | Decay select, 1 = slow |
| sr | input | 1 | Synchronous-rectification enable |
| brake_n | input | 1 | Active-low brake |
| drv_off | input | 1 | Driver disable, 1 = coast |
| boot_ok | input | 3 | Per-phase bootstrap-ready flags |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| gh | output | 3 | High-side gate enables per phase |
| gl | output | 3 | Low-side gate enables per phase |
| hall_fault | output | 1 | Illegal Hall code seen |

## Verification
The bench measures the gap between a turn-off and the opposing turn-on for two dead-time settings. A design that starts the counter one cycle late or ends it one cycle early gives a gap that differs by one edge. Each of the four recirculation patterns is checked, as well as the trip path into the off-cycle. Swapping the synchronous-rectification pattern with the slow-decay pattern, or letting trip be ignored, leaves the wrong gates on. A missing bootstrap hold is caught because the high side would rise while its phase is not ready. A wrong priority between fault, brake and disable is caught because the low sides would stay on during an illegal code or while disabled. Every cycle of the run is watched for a leg with both gates high.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;

    localparam int NPH = 3;

    typedef logic [NPH-1:0] phase_mask_t;

    // off-cycle recirculation pattern, index is {mode, sr}
    typedef enum logic [1:0] {
        DECAY_COAST    = 2'b00,
        DECAY_SR_OPP   = 2'b01,
        DECAY_LOW_ONE  = 2'b10,
        DECAY_LOW_BOTH = 2'b11
    } decay_e;

    typedef struct packed {
        logic        valid;
        phase_mask_t hi;
        phase_mask_t lo;
    } comm_t;

    typedef struct packed {
        phase_mask_t hi;
        phase_mask_t lo;
    } gate_req_t;

    function automatic logic hall_legal(input logic [2:0] code);
        return (code != 3'b000) && (code != 3'b111);
    endfunction

    // forward table; reverse swaps the two phases
    function automatic comm_t commutate(input logic [2:0] code, input logic fwd);
        comm_t       r;
        phase_mask_t a;
        phase_mask_t b;
        a = '0;
        b = '0;
        case (code)
            3'd1: begin a = 3'b001; b = 3'b100; end
            3'd2: begin a = 3'b010; b = 3'b001; end
            3'd3: begin a = 3'b010; b = 3'b100; end
            3'd4: begin a = 3'b100; b = 3'b010; end
            3'd5: begin a = 3'b001; b = 3'b010; end
            3'd6: begin a = 3'b100; b = 3'b001; end
            default: begin a = '0; b = '0; end
        endcase
        r.valid = hall_legal(code);
        r.hi    = fwd ? a : b;
        r.lo    = fwd ? b : a;
        return r;
    endfunction

endpackage

// File: rtl/hall_commutator.sv
module hall_commutator
    import bldc_gate_pkg::*;
(
    input  logic [2:0] hall,
    input  logic       dir,
    output comm_t      sel
);
    always_comb begin
        sel = commutate(hall, dir);
    end
endmodule

// File: rtl/decay_select.sv
module decay_select
    import bldc_gate_pkg::*;
(
    input  comm_t     sel,
    input  logic      chop,
    input  logic      trip,
    input  logic      mode,
    input  logic      sr,
    input  logic      brake_n,
    input  logic      drv_off,
    output gate_req_t req
);
    logic   drive_on;
    decay_e pattern;

    assign drive_on = chop && !trip;
    assign pattern  = decay_e'({mode, sr});

    // priority: disable, illegal code, brake, drive, recirculation
    always_comb begin
        req = '0;
        if (drv_off || !sel.valid) begin
            req = '0;
        end else if (!brake_n) begin
            req.hi = '0;
            req.lo = '1;
        end else if (drive_on) begin
            req.hi = sel.hi;
            req.lo = sel.lo;
        end else begin
            case (pattern)
                DECAY_COAST:    req = '0;
                DECAY_LOW_ONE:  req.lo = sel.lo;
                DECAY_SR_OPP: begin
                    req.hi = sel.lo;
                    req.lo = sel.hi;
                end
                DECAY_LOW_BOTH: req.lo = sel.hi | sel.lo;
                default:        req = '0;
            endcase
        end
    end
endmodule

// File: rtl/gate_leg_dt.sv
module gate_leg_dt #(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_h,
    input  logic            req_l,
    input  logic            boot_ok,
    input  logic [DT_W-1:0] dead,
    output logic            gh,
    output logic            gl
);
    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] cnt_n;
    logic            gh_q, gl_q, gh_n, gl_n;
    logic            expired, turnoff;

    assign expired = (cnt_q == '0);

    always_comb begin
        // a gate already on follows its request; turn-on waits for the leg
        if (gh_q) gh_n = req_h;
        else      gh_n = req_h && !req_l && expired && !gl_q && boot_ok;

        if (gl_q) gl_n = req_l;
        else      gl_n = req_l && !req_h && expired && !gh_q;

        turnoff = (gh_q && !gh_n) || (gl_q && !gl_n);

        if (turnoff)      cnt_n = dead;
        else if (expired) cnt_n = '0;
        else              cnt_n = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gh_q  <= 1'b0;
            gl_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            gh_q  <= gh_n;
            gl_q  <= gl_n;
            cnt_q <= cnt_n;
        end
    end

    assign gh = gh_q;
    assign gl = gl_q;
endmodule

// File: rtl/bldc_gate_ctrl.sv
module bldc_gate_ctrl
    import bldc_gate_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      hall,
    input  logic            dir,
    input  logic            chop,
    input  logic            trip,
    input  logic            mode,
    input  logic            sr,
    input  logic            brake_n,
    input  logic            drv_off,
    input  logic [2:0]      boot_ok,
    input  logic [DT_W-1:0] dead_cycles,
    output logic [2:0]      gh,
    output logic [2:0]      gl,
    output logic            hall_fault
);
    comm_t     sel;
    gate_req_t req;
    logic      fault_q;

    hall_commutator u_comm (
        .hall (hall),
        .dir  (dir),
        .sel  (sel)
    );

    decay_select u_decay (
        .sel     (sel),
        .chop    (chop),
        .trip    (trip),
        .mode    (mode),
        .sr      (sr),
        .brake_n (brake_n),
        .drv_off (drv_off),
        .req     (req)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_leg
        gate_leg_dt #(.DT_W(DT_W)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .req_h   (req.hi[i]),
            .req_l   (req.lo[i]),
            .boot_ok (boot_ok[i]),
            .dead    (dead_cycles),
            .gh      (gh[i]),
            .gl      (gl[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= !sel.valid;
    end

    assign hall_fault = fault_q;
endmodule

// File: rtl/bldc_gate_ctrl_chk.sv
module bldc_gate_ctrl_chk #(
    parameter int DT_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      hall,
    input logic            brake_n,
    input logic            drv_off,
    input logic [2:0]      boot_ok,
    input logic [DT_W-1:0] dead_cycles,
    input logic [2:0]      gh,
    input logic [2:0]      gl,
    input logic            hall_fault
);
    localparam int SW = DT_W + 1;

    logic [2:0]    gh_d, gl_d;
    logic [SW-1:0] since [3];

    always_ff @(posedge clk) begin
        if (rst) begin
            gh_d <= '0;
            gl_d <= '0;
        end else begin
            gh_d <= gh;
            gl_d <= gl;
        end
    end

    for (genvar i = 0; i < 3; i++) begin : g_leg_chk
        logic fell_now;
        assign fell_now = (gh_d[i] && !gh[i]) || (gl_d[i] && !gl[i]);

        always_ff @(posedge clk) begin
            if (rst)                 since[i] <= '1;
            else if (fell_now)       since[i] <= '0;
            else if (since[i] != '1) since[i] <= since[i] + 1'b1;
        end

        // R7
        hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (gh[i] && !gh_d[i]) |-> (since[i] >= {1'b0, dead_cycles}));
        // R7
        lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (gl[i] && !gl_d[i]) |-> (since[i] >= {1'b0, dead_cycles}));
        // R8
        boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(gh[i]) |-> $past(boot_ok[i]));
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (gh & gl) == 3'b000);
    // R5
    coast_off_chk: assert property (@(posedge clk) disable iff (rst)
        drv_off |=> (gh == 3'b000 && gl == 3'b000));
    // R3
    bad_hall_chk: assert property (@(posedge clk) disable iff (rst)
        (hall == 3'b000 || hall == 3'b111) |=> (hall_fault && gh == 3'b000 && gl == 3'b000));
    // R4
    brake_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!brake_n && !drv_off && hall != 3'b000 && hall != 3'b111) |=> (gh == 3'b000));
endmodule

bind bldc_gate_ctrl bldc_gate_ctrl_chk #(.DT_W(DT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hall        (hall),
    .brake_n     (brake_n),
    .drv_off     (drv_off),
    .boot_ok     (boot_ok),
    .dead_cycles (dead_cycles),
    .gh          (gh),
    .gl          (gl),
    .hall_fault  (hall_fault)
);

// File: tb/bldc_gate_ctrl_test.sv
`timescale 1ns/1ps
module bldc_gate_ctrl_test;
    localparam int DT_W = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      hall = 3'd5;
    logic            dir = 1'b1;
    logic            chop = 1'b1;
    logic            trip = 1'b0;
    logic            mode = 1'b0;
    logic            sr = 1'b0;
    logic            brake_n = 1'b1;
    logic            drv_off = 1'b0;
    logic [2:0]      boot_ok = 3'b111;
    logic [DT_W-1:0] dead = 10'd3;
    logic [2:0]      gh, gl;
    logic            hall_fault;

    int checks = 0;
    int errors = 0;
    int overlap = 0;

    always #4 clk = ~clk;

    bldc_gate_ctrl #(.DT_W(DT_W)) uut (
        .clk(clk), .rst(rst), .hall(hall), .dir(dir), .chop(chop), .trip(trip),
        .mode(mode), .sr(sr), .brake_n(brake_n), .drv_off(drv_off),
        .boot_ok(boot_ok), .dead_cycles(dead), .gh(gh), .gl(gl),
        .hall_fault(hall_fault)
    );

    // fields: hall[15:13] dir[12] chop[11] mode[10] sr[9] brake_n[8] off[7] gh[6:4] gl[3:1] fault[0]
    localparam logic [15:0] VEC [18] = '{
        {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b100, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010, 3'b001, 1'b0},
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010, 3'b100, 1'b0},
        {3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b100, 3'b010, 1'b0},
        {3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b010, 1'b0},
        {3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b100, 3'b001, 1'b0},
        {3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b100, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b100, 3'b010, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 3'b010, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b010, 3'b001, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 3'b011, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 1'b1},
        {3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000, 1'b1},
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b111, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1},
        {3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b010, 3'b100, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [2:0] egh, input logic [2:0] egl, input logic ef);
        check(req, "gates/fault", int'({gh, gl, hall_fault}), int'({egh, egl, ef}));
    endtask

    always @(negedge clk) begin
        if (!rst && ((gh & gl) != 3'b000)) overlap++;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k_a;
        int k_b;
        logic steady;

        // R11: reset holds everything off even with a driving input set
        repeat (4) @(negedge clk);
        check_out("R11", 3'b000, 3'b000, 1'b0);
        rst = 1'b0;

        // vector walk, dead time 3
        for (int i = 0; i < 18; i++) begin
            logic [15:0] v;
            string tag;
            v = VEC[i];
            hall = v[15:13]; dir = v[12]; chop = v[11]; mode = v[10];
            sr = v[9]; brake_n = v[8]; drv_off = v[7];
            repeat (12) @(negedge clk);
            if (v[7])       tag = "R5";
            else if (v[0])  tag = "R3";
            else if (!v[8]) tag = "R4";
            else if (!v[11]) tag = "R6";
            else if (!v[12]) tag = "R2";
            else            tag = "R1";
            check_out(tag, v[6:4], v[3:1], v[0]);
        end

        // R6: trip forces the off-cycle, slow decay keeps selected low side
        hall = 3'd5; dir = 1'b1; chop = 1'b1; mode = 1'b1; sr = 1'b0;
        brake_n = 1'b1; drv_off = 1'b0; trip = 1'b1;
        repeat (12) @(negedge clk);
        check_out("R6", 3'b000, 3'b010, 1'b0);
        trip = 1'b0;
        repeat (12) @(negedge clk);
        check_out("R6", 3'b001, 3'b010, 1'b0);

        // R10: chop held high keeps the pair on every cycle
        steady = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gh != 3'b001 || gl != 3'b010) steady = 1'b0;
        end
        check("R10", "steady on", int'(steady), 1);

        // R7: dead time of 5, reverse direction
        dead = 10'd5;
        repeat (12) @(negedge clk);
        dir = 1'b0;
        k_a = 0; k_b = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k_a == 0 && gl[0]) k_a = k;
            if (k_b == 0 && gh[1]) k_b = k;
        end
        check("R7", "low A rise cycle", k_a, 7);
        check("R7", "high B rise cycle", k_b, 7);
        check_out("R2", 3'b010, 3'b001, 1'b0);

        // R7: zero dead time still leaves one edge with both gates off
        dead = 10'd0;
        repeat (4) @(negedge clk);
        dir = 1'b1;
        k_a = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k_a == 0 && gh[0]) k_a = k;
        end
        check("R7", "high A rise cycle dt0", k_a, 2);

        // R8: high B held off while its bootstrap is not ready
        dead = 10'd3;
        boot_ok = 3'b101;
        hall = 3'd3;
        repeat (20) @(negedge clk);
        check_out("R8", 3'b000, 3'b100, 1'b0);
        boot_ok = 3'b111;
        @(negedge clk);
        check_out("R8", 3'b010, 3'b100, 1'b0);

        // R3: fault and coast one edge after an illegal code
        hall = 3'd0;
        @(negedge clk);
        check_out("R3", 3'b000, 3'b000, 1'b1);
        hall = 3'd3;
        @(negedge clk);
        check("R3", "fault clears", int'(hall_fault), 0);

        // R5: disable beats brake, one edge
        repeat (12) @(negedge clk);
        drv_off = 1'b1; brake_n = 1'b0;
        @(negedge clk);
        check_out("R5", 3'b000, 3'b000, 1'b0);
        drv_off = 1'b0; brake_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: no leg ever had both gates high
        check("R9", "overlap cycles", overlap, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule